// File: doc/BRIEF.md
# Dual-Clock Word RAM with Selectable Read Latency

This block is a two-port synchronous memory. One port only writes and the other only reads, and each port has its own clock. A write stores one full data word on a rising edge of the write clock. A read captures its address on a rising edge of the read clock and returns the stored word after one or two read-clock edges. A static parameter picks the latency. The one-edge variant gives the shortest path from address to data. The two-edge variant adds an output register after the array access, so the read clock can run faster.

The array has 2^ADDR_W words of DATA_W bits. The defaults are 12 address bits and 36 data bits, and the read port matches the write port in both widths. A single enable covers the whole word; there are no byte lanes. A synchronous reset on the read clock clears the read-side registers to zero and leaves the stored contents alone. The contents are undefined until they are written.

There is no state machine. The read path is a fixed chain of registers:
- The first stage captures the array word when `rd_en` is high.
- In the two-edge variant, a flag records that a read was launched, and the output register loads on the next edge only when that flag is set.

Top module: `twoclk_ram`

## Requirements
- R1: On a rising `wclk` edge with `wr_en` high, all DATA_W bits of `wr_data` are stored at `wr_addr`. A later read of that address returns the word.
- R2: On a rising `wclk` edge with `wr_en` low, no stored word changes, whatever `wr_addr` and `wr_data` carry.
- R3: With `READ_MODE` = `RD_LAT_ONE`, the word at the `rd_addr` sampled on the `rclk` edge where `rd_en` is high appears on `rd_data` right after that same edge.
- R4: With `READ_MODE` = `RD_LAT_TWO`, the word appears on `rd_data` right after the following `rclk` edge. After the launching edge itself, `rd_data` still shows the earlier result. Back-to-back reads stream one word per edge.
- R5: In one-edge mode, an `rclk` edge with `rd_en` low leaves `rd_data` unchanged, even if `rd_addr` changes.
- R6: In two-edge mode, `rd_data` changes only on the edge after a launched read. Once two consecutive edges have sampled `rd_en` low, the output holds.
- R7: When a read and a write hit the same address on the same edge of a shared clock, the read returns the contents stored before that write.
- R8: While `rrst` is high on an `rclk` edge, every read-side register, including `rd_data`, becomes zero in both modes. Stored words are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-port clock, rising edge |
| wr_en | input | 1 | Write enable for the whole word |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Word to store |
| rclk | input | 1 | Read-port clock, rising edge |
| rrst | input | 1 | Synchronous read-side reset, active high |
| rd_en | input | 1 | Read enable; starts a read on an `rclk` edge |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Read result |

## Verification
The bench builds one instance of each latency variant in a small configuration and sweeps every address with arithmetic patterns. It checks exact edge timing: a two-edge design that loaded its output one edge early would show the new word in the wrong cycle, and a one-edge design with an extra register would lag by a cycle. It checks that idle edges keep the output frozen while `rd_addr` moves; a design that read on a disabled edge would follow the address. It also aims at blocked writes carrying inverted data, same-edge read/write collisions that must return the old word, and a mid-run reset that must zero the output but keep the memory.

// File: rtl/twoclk_ram_pkg.sv
package twoclk_ram_pkg;

    typedef enum logic {
        RD_LAT_ONE = 1'b0,
        RD_LAT_TWO = 1'b1
    } rd_lat_e;

    function automatic int unsigned read_latency(rd_lat_e mode);
        return (mode == RD_LAT_TWO) ? 2 : 1;
    endfunction

endpackage

// File: rtl/twoclk_ram_array.sv
module twoclk_ram_array #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 36
) (
    input  logic              wclk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rclk,
    input  logic              rrst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // write port
    always_ff @(posedge wclk) begin
        if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    // read port: address sampled at the edge, word registered
    always_ff @(posedge rclk) begin
        if (rrst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= store[rd_addr];
        end
    end

    // probe registers, used only by the write-side check
    logic [ADDR_W-1:0] probe_addr_q;
    logic [DATA_W-1:0] probe_word_q;
    always_ff @(posedge wclk) begin
        probe_addr_q <= wr_addr;
        probe_word_q <= store[wr_addr];
    end

    // R2
    write_hold_chk: assert property (@(posedge wclk) disable iff (rrst)
        !wr_en |=> (store[probe_addr_q] == probe_word_q));

    // R5
    array_hold_chk: assert property (@(posedge rclk) disable iff (rrst)
        !rd_en |=> $stable(rd_q));

endmodule

// File: rtl/twoclk_ram_outreg.sv
module twoclk_ram_outreg #(
    parameter int DATA_W = 36
) (
    input  logic              rclk,
    input  logic              rrst,
    input  logic              load,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge rclk) begin
        if (rrst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    // R6
    outreg_hold_chk: assert property (@(posedge rclk) disable iff (rrst)
        !load |=> $stable(q));

endmodule

// File: rtl/twoclk_ram.sv
module twoclk_ram
    import twoclk_ram_pkg::*;
#(
    parameter int      ADDR_W    = 12,
    parameter int      DATA_W    = 36,
    parameter rd_lat_e READ_MODE = RD_LAT_ONE
) (
    input  logic              wclk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rclk,
    input  logic              rrst,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned LATENCY = read_latency(READ_MODE);

    logic [DATA_W-1:0] array_q;

    twoclk_ram_array #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_array (
        .wclk    (wclk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rclk    (rclk),
        .rrst    (rrst),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_q    (array_q)
    );

    generate
        if (LATENCY == 2) begin : g_pipe
            logic              launch_q;
            logic [DATA_W-1:0] out_q;

            always_ff @(posedge rclk) begin
                if (rrst) begin
                    launch_q <= 1'b0;
                end else begin
                    launch_q <= rd_en;
                end
            end

            twoclk_ram_outreg #(
                .DATA_W(DATA_W)
            ) u_outreg (
                .rclk (rclk),
                .rrst (rrst),
                .load (launch_q),
                .d    (array_q),
                .q    (out_q)
            );

            assign rd_data = out_q;

            // R6
            pipe_idle_hold_chk: assert property (@(posedge rclk) disable iff (rrst)
                (!rd_en && !launch_q) |=> ##1 $stable(rd_data));
        end else begin : g_flow
            assign rd_data = array_q;

            // R5
            flow_hold_chk: assert property (@(posedge rclk) disable iff (rrst)
                !rd_en |=> $stable(rd_data));
        end
    endgenerate

endmodule

// File: tb/twoclk_ram_tb_top.sv
module twoclk_ram_tb_top;
    import twoclk_ram_pkg::*;

    localparam int AW = 4;
    localparam int DW = 12;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    always #4 clk = ~clk;

    logic          wr_en, rrst, rd_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [DW-1:0] wr_data, rd_pipe, rd_flow;

    twoclk_ram #(.ADDR_W(AW), .DATA_W(DW), .READ_MODE(RD_LAT_TWO)) dut_i (
        .wclk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rclk(clk), .rrst(rrst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_pipe));

    twoclk_ram #(.ADDR_W(AW), .DATA_W(DW), .READ_MODE(RD_LAT_ONE)) dut_flow_i (
        .wclk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rclk(clk), .rrst(rrst), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_flow));

    int            n_run  = 0;
    int            n_fail = 0;
    logic [DW-1:0] model [N];
    logic [DW-1:0] old_w;

    function automatic logic [DW-1:0] pat(int a, int s);
        return DW'((a * 311 + s * 97 + 5) ^ (a << 7) ^ (s << 3));
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        wr_en = 0; wr_addr = '0; wr_data = '0;
        rd_en = 0; rd_addr = '0; rrst = 1;
        repeat (3) tick();
        chk("R8 reset pipe", rd_pipe, '0);
        chk("R8 reset flow", rd_flow, '0);
        rrst = 0;

        // R1: fill every word
        for (int a = 0; a < N; a++) begin
            wr_en = 1; wr_addr = AW'(a); wr_data = pat(a, 1);
            model[a] = pat(a, 1);
            tick();
        end
        wr_en = 0;

        // single reads: R3 R4 R5 R6
        for (int a = 0; a < N; a++) begin
            logic [DW-1:0] prev;
            prev = rd_pipe;
            rd_en = 1; rd_addr = AW'(a);
            tick();
            chk("R3 flow one edge", rd_flow, model[a]);
            chk("R4 pipe not early", rd_pipe, prev);
            rd_en = 0; rd_addr = AW'(a ^ 1);
            tick();
            chk("R4 pipe two edges", rd_pipe, model[a]);
            chk("R5 flow hold", rd_flow, model[a]);
            tick();
            chk("R6 pipe hold", rd_pipe, model[a]);
        end

        // streaming reads: R3 R4
        for (int i = 0; i < N; i++) begin
            rd_en = 1; rd_addr = AW'(N - 1 - i);
            tick();
            chk("R3 stream flow", rd_flow, model[N-1-i]);
            if (i > 0) chk("R4 stream pipe", rd_pipe, model[N-i]);
        end
        rd_en = 0;
        tick();
        chk("R4 stream tail", rd_pipe, model[0]);

        // R2: blocked writes carrying inverted data
        for (int a = 0; a < N; a++) begin
            wr_en = 0; wr_addr = AW'(a); wr_data = ~model[a];
            tick();
        end
        for (int a = 0; a < N; a++) begin
            rd_en = 1; rd_addr = AW'(a);
            tick();
            chk("R2 blocked write", rd_flow, model[a]);
        end
        rd_en = 0;
        tick();
        tick();

        // R7: same-edge collision returns old word
        for (int a = 0; a < N; a++) begin
            old_w = model[a];
            wr_en = 1; wr_addr = AW'(a); wr_data = pat(a, 2);
            rd_en = 1; rd_addr = AW'(a);
            tick();
            chk("R7 flow old word", rd_flow, old_w);
            model[a] = pat(a, 2);
            wr_en = 0;
            tick();
            chk("R1 flow new word", rd_flow, model[a]);
            chk("R7 pipe old word", rd_pipe, old_w);
            rd_en = 0;
            tick();
            chk("R1 pipe new word", rd_pipe, model[a]);
        end

        // R8: reset mid-run keeps memory
        rrst = 1;
        tick();
        chk("R8 mid reset pipe", rd_pipe, '0);
        chk("R8 mid reset flow", rd_flow, '0);
        rrst = 0;
        rd_en = 1; rd_addr = AW'(5);
        tick();
        chk("R8 memory kept", rd_flow, model[5]);
        rd_en = 0;
        tick();
        chk("R8 memory kept pipe", rd_pipe, model[5]);

        // R5 R6: idle edges with a moving address
        for (int a = 0; a < N; a++) begin
            rd_addr = AW'(a);
            tick();
            chk("R5 idle flow", rd_flow, model[5]);
            chk("R6 idle pipe", rd_pipe, model[5]);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule